// File: doc/BRIEF.md
# Mode-Switched Memory Map Decoder

This block sits between an 8-bit processor with a 16-bit address bus and the memories and peripherals around it. For every processor access it picks one target (the RAM, one of three ROM slots, one of four I/O windows, or nothing) and produces the address to present to that target. The choice depends on a four-bit mode register inside the block: two RAM-size bits, a map-type bit and a page bit. Software changes the mode by writing to a set of addresses near the top of the map.

The same mode bits also give a video address counter a wrap mask and an OR value, so the display fetch stays inside the active RAM size. The amount of RAM actually fitted is a parameter. A RAM-window access whose translated address lands at or beyond that amount selects nothing: a read returns all ones and a write is dropped.

Top module: `memmap_decoder`

## Requirements
- R1: After reset all four mode bits are zero. The video mask is 0x0FFF, the OR value is 0x0000, and address 0x8000 selects ROM slot 0.
- R2: A write (cpu_valid and cpu_wr high) to address 0xFFC0+2k+v sets mode bit k to v, taking effect on the next cycle. k=0 is size-low, k=1 is size-high, k=2 is page and k=3 is map-type. Other addresses in 0xFFC8–0xFFDF and all reads leave the mode unchanged.
- R3: With size bits {high,low} = 00 the video mask/OR is 0x0FFF/0. With 01 it is 0x3FFF/0. With 1x and map-type set it is 0xFFFF/0. With 1x and map-type clear it is 0x7FFF, with an OR value of 0x8000 when page is set and 0 otherwise.
- R4: Full-RAM mode (size-high and map-type both set): every address below 0xFF00 is a RAM-window access with translated address equal to the CPU address. In all other modes, 0x0000–0x7FFF is the RAM window, and the translated address is the CPU address plus a base. The base is 0x8000 when size-high is set, map-type is clear and page is set; otherwise it is 0.
- R5: Outside full-RAM mode, 0x8000–0x9FFF selects ROM slot 0 (rom_cs bit 0), 0xA000–0xBFFF selects slot 1 (bit 1) and 0xC000–0xFEFF selects slot 2 (bit 2). The address is that slot's base parameter plus the distance from the window start, modulo 2^16.
- R6: In every mode, 0xFFE0–0xFFFF selects ROM slot 1 at that slot's base plus 0x1FE0 plus the distance from 0xFFE0.
- R7: 0xFF00–0xFF1F, 0xFF20–0xFF3F, 0xFF40–0xFF5F and 0xFF60–0xFF7F select io_cs bits 0, 1, 2 and 3, with address equal to the low five CPU address bits. 0xFF80–0xFFDF selects nothing.
- R8: A RAM-window access whose translated address is at or above RAM_BYTES asserts no select.
- R9: When no select is active, including whenever cpu_valid is low, cpu_rdata is 0xFF. Otherwise cpu_rdata equals bus_rdata.
- R10: At most one select output is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Access in progress |
| cpu_wr | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address |
| bus_rdata | input | 8 | Read data from the selected target |
| ram_cs | output | 1 | RAM select |
| rom_cs | output | 3 | ROM slot selects |
| io_cs | output | 4 | I/O window selects |
| mem_addr | output | 16 | Translated target address |
| cpu_rdata | output | 8 | Read data to the CPU |
| vid_mask | output | 16 | Video counter wrap mask |
| vid_or | output | 16 | Video counter OR value |

## Verification
Some properties hold in every cycle and are checked by assertions. At most one select is active. A RAM select never carries an address beyond the installed size. The vector range always goes to ROM slot 1. An idle bus gives all-ones data. Setting size-high always widens the video mask on the next cycle. The exact target and address for each of the sixteen mode combinations can only be shown by the bench. It sweeps every 32-byte boundary, both edges, in each mode, with a reduced RAM size so that the no-op regions appear in full-RAM and paged modes. Only the bench's scenarios show that reads to the mode addresses change nothing.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter int          RAM_BYTES = 16384,
  parameter logic [15:0] ROM0_BASE = 16'h0000,
  parameter logic [15:0] ROM1_BASE = 16'h2000,
  parameter logic [15:0] ROM2_BASE = 16'h4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  bus_rdata,
  output logic        ram_cs,
  output logic [2:0]  rom_cs,
  output logic [3:0]  io_cs,
  output logic [15:0] mem_addr,
  output logic [7:0]  cpu_rdata,
  output logic [15:0] vid_mask,
  output logic [15:0] vid_or
);
  localparam int          LEN_CLAMP = (RAM_BYTES > 65536) ? 65536 : RAM_BYTES;
  localparam logic [16:0] RAM_LEN   = 17'(LEN_CLAMP);

  logic sz_lo, sz_hi, page, map_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz_lo <= 1'b0; sz_hi <= 1'b0; page <= 1'b0; map_full <= 1'b0;
    end else if (cpu_valid && cpu_wr && cpu_addr[15:5] == 11'h7FE) begin
      case (cpu_addr[4:1])
        4'd0: sz_lo    <= cpu_addr[0];
        4'd1: sz_hi    <= cpu_addr[0];
        4'd2: page     <= cpu_addr[0];
        4'd3: map_full <= cpu_addr[0];
        default: ;
      endcase
    end
  end

  wire        full     = sz_hi & map_full;
  wire [15:0] ram_base = (sz_hi & ~map_full & page) ? 16'h8000 : 16'h0000;
  wire        hi_page  = cpu_addr[15:8] == 8'hFF;
  wire        in_vec   = cpu_addr[15:5] == 11'h7FF;
  wire        in_io    = cpu_addr[15:7] == 9'h1FE;
  wire        ram_win  = ~hi_page & (~cpu_addr[15] | full);
  wire [16:0] ram_off  = full ? {1'b0, cpu_addr}
                              : {1'b0, ram_base} + {2'b00, cpu_addr[14:0]};
  wire        ram_ok   = ram_off < RAM_LEN;

  always_comb begin
    ram_cs   = 1'b0;
    rom_cs   = 3'b000;
    io_cs    = 4'b0000;
    mem_addr = 16'h0000;
    if (cpu_valid) begin
      if (in_vec) begin
        rom_cs   = 3'b010;
        mem_addr = ROM1_BASE + {3'b000, cpu_addr[12:0]};
      end else if (in_io) begin
        io_cs    = 4'b0001 << cpu_addr[6:5];
        mem_addr = {11'h000, cpu_addr[4:0]};
      end else if (hi_page) begin
        mem_addr = 16'h0000;
      end else if (ram_win) begin
        ram_cs   = ram_ok;
        mem_addr = ram_off[15:0];
      end else if (cpu_addr[14]) begin
        rom_cs   = 3'b100;
        mem_addr = ROM2_BASE + {2'b00, cpu_addr[13:0]};
      end else if (cpu_addr[13]) begin
        rom_cs   = 3'b010;
        mem_addr = ROM1_BASE + {3'b000, cpu_addr[12:0]};
      end else begin
        rom_cs   = 3'b001;
        mem_addr = ROM0_BASE + {3'b000, cpu_addr[12:0]};
      end
    end
  end

  assign cpu_rdata = (ram_cs | (|rom_cs) | (|io_cs)) ? bus_rdata : 8'hFF;

  always_comb begin
    case ({sz_hi, sz_lo})
      2'b00:   vid_mask = 16'h0FFF;
      2'b01:   vid_mask = 16'h3FFF;
      default: vid_mask = full ? 16'hFFFF : 16'h7FFF;
    endcase
  end
  assign vid_or = ram_base;

  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, rom_cs, io_cs}));
  a_r6_vector_rom1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr[15:5] == 11'h7FF) |-> (rom_cs == 3'b010 && !ram_cs && io_cs == 4'b0000));
  a_r8_ram_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> ({1'b0, mem_addr} < RAM_LEN));
  a_r9_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> (!ram_cs && rom_cs == 3'b000 && io_cs == 4'b0000 && cpu_rdata == 8'hFF));
  a_r2_size_hi_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_wr && cpu_addr == 16'hFFC3) |=> (vid_mask[14:0] == 15'h7FFF));
  a_r3_full_no_or: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_mask == 16'hFFFF) |-> (vid_or == 16'h0000));
endmodule

// File: tb/sim_memmap_decoder.sv
`timescale 1ns/1ps
module sim_memmap_decoder;
  localparam int RAMB = 16'h6000;
  localparam int B0 = 16'h1000, B1 = 16'hF000, B2 = 16'h3000;

  logic clk = 0, rst_n = 0, cpu_valid = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] bus_rdata = 0;
  logic ram_cs; logic [2:0] rom_cs; logic [3:0] io_cs;
  logic [15:0] mem_addr, vid_mask, vid_or; logic [7:0] cpu_rdata;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  memmap_decoder #(.RAM_BYTES(RAMB), .ROM0_BASE(16'(B0)), .ROM1_BASE(16'(B1)), .ROM2_BASE(16'(B2))) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .bus_rdata(bus_rdata), .ram_cs(ram_cs), .rom_cs(rom_cs), .io_cs(io_cs), .mem_addr(mem_addr),
    .cpu_rdata(cpu_rdata), .vid_mask(vid_mask), .vid_or(vid_or));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, cpu_addr);
    end
  endtask

  task automatic ctrl_write(input int k, input int v);
    @(negedge clk);
    cpu_valid = 1; cpu_wr = 1; cpu_addr = 16'(16'hFFC0 + 2*k + v);
    @(negedge clk);
    cpu_valid = 0; cpu_wr = 0;
  endtask

  task automatic check_vid(input int m, input string req);
    int mask, orv, base;
    base = (m[1] && !m[3] && m[2]) ? 16'h8000 : 0;
    case (m & 3)
      0: mask = 16'h0FFF;
      1: mask = 16'h3FFF;
      default: mask = m[3] ? 16'hFFFF : 16'h7FFF;
    endcase
    orv = base;
    #1;
    chk({req, " mask"}, int'(vid_mask), mask);
    chk({req, " or"}, int'(vid_or), orv);
  endtask

  // sel: 0 none, 1 ram, 2..4 rom0..2, 5..8 io0..3
  task automatic probe(input int m, input int a);
    int sel, ea, base, off, expsel, actsel;
    string req;
    bit full;
    full = m[1] && m[3];
    base = (m[1] && !m[3] && m[2]) ? 16'h8000 : 0;
    sel = 0; ea = 0; req = "R9";
    if (a >= 16'hFFE0) begin sel = 3; ea = (B1 + 16'h1FE0 + a - 16'hFFE0) & 16'hFFFF; req = "R6"; end
    else if (a >= 16'hFF00 && a < 16'hFF80) begin sel = 5 + (a - 16'hFF00) / 32; ea = a % 32; req = "R7"; end
    else if (a >= 16'hFF00) begin sel = 0; req = "R7"; end
    else if (full || a < 16'h8000) begin
      off = full ? a : base + a;
      if (off < RAMB) begin sel = 1; ea = off; req = "R4"; end
      else begin sel = 0; req = "R8"; end
    end
    else if (a < 16'hA000) begin sel = 2; ea = (B0 + a - 16'h8000) & 16'hFFFF; req = "R5"; end
    else if (a < 16'hC000) begin sel = 3; ea = (B1 + a - 16'hA000) & 16'hFFFF; req = "R5"; end
    else begin sel = 4; ea = (B2 + a - 16'hC000) & 16'hFFFF; req = "R5"; end
    @(negedge clk);
    cpu_valid = 1; cpu_wr = 0; cpu_addr = 16'(a); bus_rdata = 8'(a) ^ 8'h5A;
    #2;
    expsel = (sel == 0) ? 0 : (1 << (sel - 1));
    actsel = {24'd0, io_cs, rom_cs, ram_cs};
    vectors++;
    if (actsel != expsel || (sel != 0 && int'(mem_addr) != ea) ||
        int'(cpu_rdata) != ((sel == 0) ? 8'hFF : int'(bus_rdata))) begin
      errors++;
      $display("FAIL %s/R10 mode %0d: actual sel %b addr %h data %h expected sel %b addr %h",
               req, m, actsel[7:0], mem_addr, cpu_rdata, expsel[7:0], ea);
    end
  endtask

  initial begin
    #(5.0 * 300000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_vid(0, "R1");
    probe(0, 16'h8000);
    chk("R1 rom0 at 8000", int'(rom_cs), 1);
    // R9 idle bus
    @(negedge clk); cpu_valid = 0; cpu_addr = 16'h0010; bus_rdata = 8'h12; #1;
    chk("R9 idle data", int'(cpu_rdata), 8'hFF);
    chk("R9 idle ram_cs", int'(ram_cs), 0);
    // R2 reads and unused addresses leave mode alone
    @(negedge clk); cpu_valid = 1; cpu_wr = 0; cpu_addr = 16'hFFC3;
    @(negedge clk); cpu_valid = 1; cpu_wr = 1; cpu_addr = 16'hFFC9;
    @(negedge clk); cpu_valid = 0; cpu_wr = 0;
    check_vid(0, "R2 read ignored");
    ctrl_write(1, 1);
    check_vid(2, "R2 size-high set");
    ctrl_write(1, 0);
    check_vid(0, "R2 size-high clear");
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 4; k++) ctrl_write(k, (m >> k) & 1);
      check_vid(m, "R3");
      for (int blk = 0; blk < 2048; blk++) begin
        probe(m, blk * 32);
        probe(m, blk * 32 + 31);
      end
    end
    @(negedge clk); cpu_valid = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule